// File: doc/BRIEF.md
# Dual-Issue Bundle Conflict Checker

This block sits in the decode stage of a two-slot pipeline. It judges the pair of instructions issued together in one bundle. A slot is enabled when its guarding predicate reads true. When both slots are enabled and compete for a resource that a bundle may use only once, the block flags the bundle as illegal and reports which resource class collided.

Each slot supplies a 4-bit instruction kind and a 3-bit predicate index. The block looks up both predicates in an 8-bit predicate file vector and maps each kind to resource flags: load, store, stack, main memory and control flow. It then applies four checks in a fixed priority and registers one error code. Checking is done only while the permissive dual-issue mode input is high and a bundle is present in decode.

Top module: `bundle_conflict_checker`

## Requirements
- R1: After reset, and until the first checked bundle, err_valid is 0 and err_code is 0.
- R2: While perm_mode is low, err_valid stays 0 and err_code stays 0 whatever the slots hold.
- R3: A bundle is checked only when both slots are enabled. Predicate index 0 always reads true. Any other index i reads pred_file[i]. If either slot is disabled, the code is 0.
- R4: If each slot is a load or a store, in any mix, the code is 1 (load/store). This check has the highest priority.
- R5: Otherwise, if both slots are stack operations, the code is 2 (stack).
- R6: Otherwise, if both slots are main-memory operations, the code is 3 (main memory).
- R7: Otherwise, if both slots are control flow, the code is 4 (control flow). This check has the lowest priority. With no match the code is 0.
- R8: Kind encoding and resource classes:
  - 0 = ALU: no class.
  - 1 = stack load, 5 = stack store: load or store, plus stack.
  - 2 = local load, 6 = local store: load or store only.
  - 3 = data-cache load, 4 = main load, 7 = data-cache store, 8 = main store: load or store, plus main memory.
  - 9 = stack control: stack and main memory.
  - 10 = call, 11 = return, 12 = exception return, 13 = trap, 15 = branch with cache fill: main memory and control flow.
  - 14 = plain branch: control flow only.
- R9: The code for a bundle presented in cycle N appears on the outputs in cycle N+1. It lasts only that one cycle. err_valid is 1 exactly when err_code is nonzero.
- R10: In a cycle where dec_valid is low, no bundle is checked, and the next cycle shows err_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_mode | input | 1 | Enables permissive dual-issue checking |
| dec_valid | input | 1 | A bundle is present in decode |
| slot0_kind | input | 4 | Instruction kind of slot 0 (R8 encoding) |
| slot0_pidx | input | 3 | Predicate index guarding slot 0 |
| slot1_kind | input | 4 | Instruction kind of slot 1 (R8 encoding) |
| slot1_pidx | input | 3 | Predicate index guarding slot 1 |
| pred_file | input | 8 | Current predicate register values |
| err_valid | output | 1 | Illegal bundle flagged, one cycle |
| err_code | output | 3 | 0 none, 1 load/store, 2 stack, 3 main memory, 4 control flow |

## Verification
The only state is the registered result, so any internal fault shows at the ports in the cycle after the bundle that exposed it. A wrong class in the table, or a wrong order of checks, gives a wrong code on the first bundle that pairs the affected kinds. A stuck or stretched result register shows as an error that does not clear in the cycle after an idle or legal bundle. The directed pairs cover each priority boundary: a load/store pair that is also a stack pair, a main-memory pair that is also control flow, and a call next to a stack store that must pass.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
    localparam int NUM_SLOTS = 2;
    localparam int KIND_W    = 4;
    localparam int NUM_PREDS = 8;
    localparam int PIDX_W    = $clog2(NUM_PREDS);
    localparam int CODE_W    = 3;

    typedef enum logic [KIND_W-1:0] {
        K_ALU      = 4'd0,
        K_LD_STK   = 4'd1,
        K_LD_LOC   = 4'd2,
        K_LD_DC    = 4'd3,
        K_LD_MEM   = 4'd4,
        K_ST_STK   = 4'd5,
        K_ST_LOC   = 4'd6,
        K_ST_DC    = 4'd7,
        K_ST_MEM   = 4'd8,
        K_STK_CTL  = 4'd9,
        K_CALL     = 4'd10,
        K_RET      = 4'd11,
        K_XRET     = 4'd12,
        K_TRAP     = 4'd13,
        K_BR       = 4'd14,
        K_BR_FILL  = 4'd15
    } instr_kind_e;

    typedef enum logic [CODE_W-1:0] {
        E_NONE  = 3'd0,
        E_LDST  = 3'd1,
        E_STACK = 3'd2,
        E_MAIN  = 3'd3,
        E_FLOW  = 3'd4
    } err_code_e;

    typedef struct packed {
        logic ld;
        logic st;
        logic stk;
        logic mm;
        logic cf;
    } res_flags_t;

    typedef struct packed {
        logic      valid;
        err_code_e code;
    } chk_state_t;
endpackage

// File: rtl/bchk_classify.sv
module bchk_classify
    import bchk_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    output res_flags_t        flags
);
    instr_kind_e k;

    always_comb begin
        k     = instr_kind_e'(kind);
        flags = '0;
        unique case (k)
            K_LD_STK:  begin flags.ld = 1'b1; flags.stk = 1'b1; end
            K_LD_LOC:  flags.ld = 1'b1;
            K_LD_DC,
            K_LD_MEM:  begin flags.ld = 1'b1; flags.mm = 1'b1; end
            K_ST_STK:  begin flags.st = 1'b1; flags.stk = 1'b1; end
            K_ST_LOC:  flags.st = 1'b1;
            K_ST_DC,
            K_ST_MEM:  begin flags.st = 1'b1; flags.mm = 1'b1; end
            K_STK_CTL: begin flags.stk = 1'b1; flags.mm = 1'b1; end
            K_CALL,
            K_RET,
            K_XRET,
            K_TRAP,
            K_BR_FILL: begin flags.mm = 1'b1; flags.cf = 1'b1; end
            K_BR:      flags.cf = 1'b1;
            default:   flags = '0;
        endcase
    end
endmodule

// File: rtl/bchk_pred_read.sv
module bchk_pred_read
    import bchk_pkg::*;
(
    input  logic [NUM_PREDS-1:0] pred_file,
    input  logic [PIDX_W-1:0]    pidx,
    output logic                 enabled
);
    always_comb begin
        if (pidx == '0) enabled = 1'b1;
        else            enabled = pred_file[pidx];
    end
endmodule

// File: rtl/bchk_arbiter.sv
module bchk_arbiter
    import bchk_pkg::*;
(
    input  res_flags_t a,
    input  res_flags_t b,
    output err_code_e  code
);
    logic mem_a, mem_b;

    always_comb begin
        mem_a = a.ld | a.st;
        mem_b = b.ld | b.st;
        if (mem_a && mem_b)      code = E_LDST;
        else if (a.stk && b.stk) code = E_STACK;
        else if (a.mm && b.mm)   code = E_MAIN;
        else if (a.cf && b.cf)   code = E_FLOW;
        else                     code = E_NONE;
    end
endmodule

// File: rtl/bundle_conflict_checker.sv
module bundle_conflict_checker
    import bchk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 perm_mode,
    input  logic                 dec_valid,
    input  logic [KIND_W-1:0]    slot0_kind,
    input  logic [PIDX_W-1:0]    slot0_pidx,
    input  logic [KIND_W-1:0]    slot1_kind,
    input  logic [PIDX_W-1:0]    slot1_pidx,
    input  logic [NUM_PREDS-1:0] pred_file,
    output logic                 err_valid,
    output logic [CODE_W-1:0]    err_code
);
    logic [KIND_W-1:0] kinds [NUM_SLOTS];
    logic [PIDX_W-1:0] pidxs [NUM_SLOTS];
    res_flags_t        flags [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] en;
    err_code_e         raw_code;
    chk_state_t        st_d, st_q;

    assign kinds[0] = slot0_kind;
    assign kinds[1] = slot1_kind;
    assign pidxs[0] = slot0_pidx;
    assign pidxs[1] = slot1_pidx;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        bchk_classify u_cls (
            .kind  (kinds[s]),
            .flags (flags[s])
        );
        bchk_pred_read u_prd (
            .pred_file (pred_file),
            .pidx      (pidxs[s]),
            .enabled   (en[s])
        );
    end

    bchk_arbiter u_arb (
        .a    (flags[0]),
        .b    (flags[1]),
        .code (raw_code)
    );

    always_comb begin
        st_d = '0;
        if (perm_mode && dec_valid && (&en)) begin
            st_d.code  = raw_code;
            st_d.valid = (raw_code != E_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_valid = st_q.valid;
    assign err_code  = st_q.code;
endmodule

// File: rtl/bundle_conflict_checker_sva.sv
module bundle_conflict_checker_sva
    import bchk_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 perm_mode,
    input logic                 dec_valid,
    input logic [PIDX_W-1:0]    slot0_pidx,
    input logic [PIDX_W-1:0]    slot1_pidx,
    input logic [NUM_PREDS-1:0] pred_file,
    input logic                 err_valid,
    input logic [CODE_W-1:0]    err_code
);
    logic on0, on1;
    assign on0 = (slot0_pidx == '0) || pred_file[slot0_pidx];
    assign on1 = (slot1_pidx == '0) || pred_file[slot1_pidx];

    a_r2_mode_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !perm_mode |=> (!err_valid && err_code == '0));

    a_r3_disabled_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !(on0 && on1) |=> !err_valid);

    a_r9_valid_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid == (err_code != '0));

    a_r7_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        err_code <= 3'd4);

    a_r10_idle_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> !err_valid);
endmodule

bind bundle_conflict_checker bundle_conflict_checker_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .perm_mode  (perm_mode),
    .dec_valid  (dec_valid),
    .slot0_pidx (slot0_pidx),
    .slot1_pidx (slot1_pidx),
    .pred_file  (pred_file),
    .err_valid  (err_valid),
    .err_code   (err_code)
);

// File: tb/bundle_conflict_checker_test.sv
module bundle_conflict_checker_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       perm_mode;
    logic       dec_valid;
    logic [3:0] slot0_kind, slot1_kind;
    logic [2:0] slot0_pidx, slot1_pidx;
    logic [7:0] pred_file;
    logic       err_valid;
    logic [2:0] err_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bundle_conflict_checker uut (
        .clk(clk), .rst_n(rst_n), .perm_mode(perm_mode), .dec_valid(dec_valid),
        .slot0_kind(slot0_kind), .slot0_pidx(slot0_pidx),
        .slot1_kind(slot1_kind), .slot1_pidx(slot1_pidx),
        .pred_file(pred_file), .err_valid(err_valid), .err_code(err_code)
    );

    // Class membership by the R8 encoding
    function automatic bit is_ld(input int k);  return k >= 1 && k <= 4; endfunction
    function automatic bit is_st(input int k);  return k >= 5 && k <= 8; endfunction
    function automatic bit is_stk(input int k); return k == 1 || k == 5 || k == 9; endfunction
    function automatic bit is_cf(input int k);  return k >= 10; endfunction
    function automatic bit is_mm(input int k);
        return k == 3 || k == 4 || k == 7 || k == 8 || k == 9 || (k >= 10 && k != 14);
    endfunction

    function automatic int expect_code(input int a, input int b);
        if ((is_ld(a) || is_st(a)) && (is_ld(b) || is_st(b))) return 1;
        if (is_stk(a) && is_stk(b)) return 2;
        if (is_mm(a) && is_mm(b))   return 3;
        if (is_cf(a) && is_cf(b))   return 4;
        return 0;
    endfunction

    task automatic check(input string req, input int exp_code);
        checks++;
        if (err_code != 3'(exp_code) || err_valid != (exp_code != 0)) begin
            errors++;
            $display("FAIL %s: code=%0d valid=%0b expected code=%0d valid=%0b",
                     req, err_code, err_valid, exp_code, exp_code != 0);
        end
    endtask

    // Drive at negedge, capture at posedge, sample at the following negedge
    task automatic bundle(input string req, input bit mode, input bit vld,
                          input int k0, input int p0, input int k1, input int p1,
                          input logic [7:0] pf, input int exp_code);
        perm_mode  = mode;
        dec_valid  = vld;
        slot0_kind = 4'(k0);
        slot0_pidx = 3'(p0);
        slot1_kind = 4'(k1);
        slot1_pidx = 3'(p1);
        pred_file  = pf;
        @(posedge clk);
        @(negedge clk);
        check(req, exp_code);
    endtask

    task automatic pair(input string req, input int k0, input int k1);
        bundle(req, 1, 1, k0, 0, k1, 0, 8'h00, expect_code(k0, k1));
    endtask

    task automatic t_reset;
        rst_n = 0; perm_mode = 1; dec_valid = 1;
        slot0_kind = 4'd4; slot1_kind = 4'd8; slot0_pidx = 0; slot1_pidx = 0; pred_file = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 0);
        rst_n = 1;
    endtask

    task automatic t_ldst;
        pair("R4 load+load", 4, 3);
        pair("R4 store+store", 8, 7);
        pair("R4 load+store local", 2, 6);
        pair("R4 stack load+stack store priority", 1, 5);
    endtask

    task automatic t_stack;
        pair("R5 stackctl+stack load", 9, 1);
        pair("R5 stackctl+stackctl priority", 9, 9);
    endtask

    task automatic t_main;
        pair("R6 call+main store", 10, 8);
        pair("R6 fill branch+dcache load", 15, 3);
        pair("R6 call+return priority", 10, 11);
        pair("R8 call+stack store legal", 10, 5);
        pair("R8 local store+call legal", 6, 10);
        pair("R8 stackctl+trap main", 9, 13);
    endtask

    task automatic t_flow;
        pair("R7 call+plain branch", 10, 14);
        pair("R7 plain+plain branch", 14, 14);
        pair("R7 alu+alu none", 0, 0);
    endtask

    task automatic t_preds;
        bundle("R3 slot1 pred false", 1, 1, 4, 0, 8, 3, 8'b1111_0111, 0);
        bundle("R3 slot0 pred false", 1, 1, 14, 5, 14, 0, 8'b1101_1111, 0);
        bundle("R3 both preds true", 1, 1, 4, 3, 8, 6, 8'b0100_1000, 1);
        bundle("R3 index0 true though bit0 clear", 1, 1, 10, 0, 11, 0, 8'b0000_0000, 3);
    endtask

    task automatic t_mode;
        bundle("R2 mode off", 0, 1, 4, 0, 8, 0, 8'hFF, 0);
        bundle("R2 mode off flow", 0, 1, 14, 0, 14, 0, 8'hFF, 0);
    endtask

    task automatic t_pulse;
        bundle("R9 error cycle", 1, 1, 9, 0, 9, 0, 8'h00, 2);
        bundle("R10 idle after error", 1, 0, 9, 0, 9, 0, 8'h00, 0);
        bundle("R9 back to back first", 1, 1, 14, 0, 10, 0, 8'h00, 4);
        bundle("R9 back to back second", 1, 1, 3, 0, 7, 0, 8'h00, 1);
        bundle("R9 legal clears", 1, 1, 0, 0, 4, 0, 8'h00, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ldst();
        t_stack();
        t_main();
        t_flow();
        t_preds();
        t_mode();
        t_pulse();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule